// File: doc/BRIEF.md
# Serial ADC Command Front-End Model

This block is a device-side behavioural model of the digital serial port of a multi-channel converter. A host controller under test drives chip select, serial clock and serial data. The model runs on its own system clock and passes those three pins through synchronisers before any decoding. Each frame begins at the first 1 seen on DIN, which may follow any number of zeros. The 1 is followed by a channel number, a single-ended/differential flag and a three-bit range code.

A command whose flag and range bits are all zero asks for a conversion. Any other command rewrites the stored setting of the named channel. A conversion publishes the channel, mode and range that apply. When a pair is set up as differential, these come from the even (positive) member of the pair. The host model reads them and places a sample on a parallel input. The model captures that sample and shifts it out MSB first in the last sixteen clocks of a 32-clock frame. The serial output is enabled only while chip select is low. The strobe output stays low.

Top module: `adc_cmd_port`

## Requirements
- R1: While chip select is low, zeros on DIN at rising SCLK edges are skipped, however many there are. The first 1 is clock 1 of a frame.
- R2: Clocks 2..8 carry the payload, MSB first. Channel C2..C0 comes first, then the mode bit (1 = differential), then range R2..R0.
- R3: A payload whose mode and range bits are all 0 is a conversion. It raises `conv_o` for one cycle and leaves the table unchanged. Any other payload writes mode and range into the entry of its channel and raises no `conv_o`.
- R4: In a conversion frame, `dout_o` carries the sample MSB first. B15 is driven at the falling edge that ends clock 16, and each later falling edge moves to the next bit, up to B0. B0 is valid at clock 32. During clocks 9..16, `dout_o` is 0.
- R5: While chip select is high, `dout_oe_o` is 0 and SCLK/DIN activity has no effect on the table or on `conv_o`. While chip select is low, `dout_oe_o` is 1.
- R6: `sstrb_o` is 0 at all times.
- R7: On a conversion of channel c, let e be c with bit 0 cleared. If entry e has its mode bit set, `sel_ch_o`=e and mode and range come from entry e. Otherwise `sel_ch_o`=c and mode and range come from entry c. The `sel_*` outputs hold until the next conversion.
- R8: If chip select rises mid-frame, the frame is dropped, the bit count restarts and no table entry changes.
- R9: After reset, every entry is single-ended with range code 111. `dout_o`, `dout_oe_o` and the `sel_*` outputs are 0.
- R10: After a configuration command, or after clock 32 of a conversion, the model hunts again for a start bit within the same chip-select low period.
- R11: `sample_i` is captured at the falling SCLK edge that ends clock 16. Later changes do not alter the bits being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| din_i | input | 1 | Serial command data from host |
| sample_i | input | SAMPLE_W | Sample for the published channel |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for `dout_o` (0 = high impedance) |
| sstrb_o | output | 1 | Strobe, held low |
| conv_o | output | 1 | One-cycle pulse when a conversion command is decoded |
| sel_ch_o | output | CH_W | Channel of the last conversion after pair resolution |
| sel_diff_o | output | 1 | Mode bit applied to the last conversion |
| sel_range_o | output | 3 | Range code applied to the last conversion |

## Verification
The bench builds the block with its defaults: eight channels, 16-bit samples and two synchroniser stages. With these values the 7-bit payload has only 128 codes, so every one of them is sent once, with a varying number of leading zeros. Every conversion is compared against a table model kept in the bench. A second sweep writes mixed single-ended and differential settings into all eight entries and converts every channel, so both members of each pair are resolved both ways. Aborted frames, writes attempted while deselected, back-to-back commands under one chip select and a late change of the sample are then checked against the same model.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int RNG_W = 3;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic             diff;
    logic [RNG_W-1:0] rng;
  } ch_cfg_t;

  localparam int      CFG_W       = $bits(ch_cfg_t);
  localparam ch_cfg_t CFG_DEFAULT = '{diff: 1'b0, rng: {RNG_W{1'b1}}};
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_VAL;
    else     chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= RST_VAL;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_cfg_table.sv
module adc_cfg_table
  import adc_cmd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  ch_cfg_t         wr_cfg_i,
  input  logic [CH_W-1:0] rd_a_ch_i,
  output ch_cfg_t         rd_a_cfg_o,
  input  logic [CH_W-1:0] rd_b_ch_i,
  output ch_cfg_t         rd_b_cfg_o
);
  ch_cfg_t [NUM_CH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= CFG_DEFAULT;
    end else if (wr_en_i) begin
      mem_q[wr_ch_i] <= wr_cfg_i;
    end
  end

  assign rd_a_cfg_o = mem_q[rd_a_ch_i];
  assign rd_b_cfg_o = mem_q[rd_b_ch_i];

  // R3: a write lands in the addressed entry
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> mem_q[$past(wr_ch_i)] == $past(wr_cfg_i));

  // R8: with no write strobe the table holds
  p_table_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_s,
  input  logic                sclk_s,
  input  logic                din_s,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [CH_W-1:0]     rd_a_ch_o,
  output logic [CH_W-1:0]     rd_b_ch_o,
  input  ch_cfg_t             rd_a_cfg_i,
  input  ch_cfg_t             rd_b_cfg_i,
  output logic                wr_en_o,
  output logic [CH_W-1:0]     wr_ch_o,
  output ch_cfg_t             wr_cfg_o,
  output logic                conv_o,
  output logic [CH_W-1:0]     sel_ch_o,
  output ch_cfg_t             sel_cfg_o,
  output logic                dout_o,
  output logic                dout_oe_o
);
  localparam int PAY_W     = CH_W + CFG_W;
  localparam int FRAME_LEN = 2 * (PAY_W + 1) + SAMPLE_W;
  localparam int LOAD_AT   = FRAME_LEN - SAMPLE_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  frame_st_e           st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [PAY_W-1:0]    pay_q;
  logic [SAMPLE_W-1:0] sh_q;
  logic                sclk_d;
  logic                sclk_rise, sclk_fall;
  logic [PAY_W-1:0]    nxt;
  logic [CH_W-1:0]     nxt_ch, nxt_even;
  ch_cfg_t             nxt_cfg;
  logic                nxt_is_conv;

  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign nxt         = {pay_q[PAY_W-2:0], din_s};
  assign nxt_ch      = nxt[PAY_W-1 -: CH_W];
  assign nxt_even    = nxt_ch & ~CH_W'(1);
  assign nxt_cfg     = ch_cfg_t'(nxt[CFG_W-1:0]);
  assign nxt_is_conv = (nxt[CFG_W-1:0] == '0);
  assign rd_a_ch_o   = nxt_ch;
  assign rd_b_ch_o   = nxt_even;
  assign dout_o      = sh_q[SAMPLE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      cnt_q     <= '0;
      pay_q     <= '0;
      sh_q      <= '0;
      sclk_d    <= 1'b0;
      dout_oe_o <= 1'b0;
      conv_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_ch_o   <= '0;
      wr_cfg_o  <= CFG_DEFAULT;
      sel_ch_o  <= '0;
      sel_cfg_o <= '0;
    end else begin
      sclk_d    <= sclk_s;
      dout_oe_o <= ~cs_s;
      conv_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      if (cs_s) begin
        st_q  <= ST_HUNT;
        cnt_q <= '0;
        pay_q <= '0;
        sh_q  <= '0;
      end else begin
        if (sclk_rise) begin
          unique case (st_q)
            ST_HUNT: if (din_s) begin
              st_q  <= ST_CMD;
              cnt_q <= CNT_W'(1);
              pay_q <= '0;
            end
            ST_CMD: begin
              pay_q <= nxt;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(PAY_W)) begin
                if (nxt_is_conv) begin
                  st_q   <= ST_DATA;
                  conv_o <= 1'b1;
                  if (rd_b_cfg_i.diff) begin
                    sel_ch_o  <= nxt_even;
                    sel_cfg_o <= rd_b_cfg_i;
                  end else begin
                    sel_ch_o  <= nxt_ch;
                    sel_cfg_o <= rd_a_cfg_i;
                  end
                end else begin
                  st_q     <= ST_HUNT;
                  cnt_q    <= '0;
                  wr_en_o  <= 1'b1;
                  wr_ch_o  <= nxt_ch;
                  wr_cfg_o <= nxt_cfg;
                end
              end
            end
            ST_DATA: begin
              if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                st_q  <= ST_HUNT;
                cnt_q <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: st_q <= ST_HUNT;
          endcase
        end
        if (sclk_fall) begin
          if (st_q == ST_DATA && cnt_q == CNT_W'(LOAD_AT))
            sh_q <= sample_i;
          else if (st_q == ST_DATA && cnt_q > CNT_W'(LOAD_AT))
            sh_q <= sh_q << 1;
          else
            sh_q <= '0;
        end
      end
    end
  end

  // R5: output driver turns off after chip select goes high
  p_oe_off_when_deselected_r5: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !dout_oe_o);

  // R4: serial output moves only after a falling serial clock edge
  p_dout_moves_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_s) |=> $stable(dout_o));

  // R8: nothing is decoded while deselected
  p_no_decode_when_deselected_r8: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!wr_en_o && !conv_o));

  // R3: a command is either a write or a conversion, never both
  p_cmd_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en_o, conv_o}));

  // R10: bit counter stays within one frame
  p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_LEN));
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import adc_cmd_pkg::*;
#(
  parameter  int NUM_CH      = 8,
  parameter  int SAMPLE_W    = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n_i,
  input  logic                sclk_i,
  input  logic                din_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                dout_o,
  output logic                dout_oe_o,
  output logic                sstrb_o,
  output logic                conv_o,
  output logic [CH_W-1:0]     sel_ch_o,
  output logic                sel_diff_o,
  output logic [RNG_W-1:0]    sel_range_o
);
  logic [2:0]      pins_s;
  logic            wr_en;
  logic [CH_W-1:0] wr_ch, rd_a_ch, rd_b_ch;
  ch_cfg_t         wr_cfg, rd_a_cfg, rd_b_cfg, sel_cfg;

  adc_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, sclk_i, din_i}),
    .q_o (pins_s)
  );

  adc_cfg_table #(.NUM_CH(NUM_CH), .CH_W(CH_W)) table_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_ch_i    (wr_ch),
    .wr_cfg_i   (wr_cfg),
    .rd_a_ch_i  (rd_a_ch),
    .rd_a_cfg_o (rd_a_cfg),
    .rd_b_ch_i  (rd_b_ch),
    .rd_b_cfg_o (rd_b_cfg)
  );

  adc_frame_ctrl #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (pins_s[2]),
    .sclk_s     (pins_s[1]),
    .din_s      (pins_s[0]),
    .sample_i   (sample_i),
    .rd_a_ch_o  (rd_a_ch),
    .rd_b_ch_o  (rd_b_ch),
    .rd_a_cfg_i (rd_a_cfg),
    .rd_b_cfg_i (rd_b_cfg),
    .wr_en_o    (wr_en),
    .wr_ch_o    (wr_ch),
    .wr_cfg_o   (wr_cfg),
    .conv_o     (conv_o),
    .sel_ch_o   (sel_ch_o),
    .sel_cfg_o  (sel_cfg),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o)
  );

  assign sel_diff_o  = sel_cfg.diff;
  assign sel_range_o = sel_cfg.rng;
  assign sstrb_o     = 1'b0;
endmodule

// File: tb/adc_cmd_port_tb_top.sv
module adc_cmd_port_tb_top;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [15:0] seed = 16'h1234;
  logic [15:0] sample;
  logic        dout, oe, sstrb, conv, sel_diff;
  logic [2:0]  sel_ch, sel_rng;

  int errors = 0, checks = 0, convs = 0;
  logic       md [8];
  logic [2:0] mr [8];

  function automatic logic [15:0] pat(input logic [15:0] sd, input logic [2:0] ch);
    return sd ^ {ch, 13'h0} ^ {13'h0, ch};
  endfunction

  assign sample = pat(seed, sel_ch);

  adc_cmd_port dut_i (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .sample_i(sample), .dout_o(dout), .dout_oe_o(oe), .sstrb_o(sstrb),
    .conv_o(conv), .sel_ch_o(sel_ch), .sel_diff_o(sel_diff), .sel_range_o(sel_rng)
  );

  always @(posedge clk) if (!rst && conv) convs++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    din = b;
    tick(H);
    seen = dout;
    sclk = 1'b1;
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic cs_fall();
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic cs_rise();
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic send(input logic [6:0] pay, input int nlead);
    logic s;
    for (int i = 0; i < nlead; i++) clk_bit(1'b0, s);
    clk_bit(1'b1, s);
    for (int i = 6; i >= 0; i--) clk_bit(pay[i], s);
  endtask

  task automatic grab(output logic [15:0] res, output logic [7:0] pre, input bit flip17);
    logic s;
    for (int k = 9; k <= 32; k++) begin
      clk_bit(1'b0, s);
      if (k <= 16) pre[16-k] = s;
      else         res[32-k] = s;
      if (flip17 && k == 17) seed = ~seed;
    end
  endtask

  task automatic resolve(input logic [2:0] c, output logic [2:0] ech, output logic ed, output logic [2:0] er);
    logic [2:0] e;
    e = {c[2:1], 1'b0};
    if (md[e]) begin ech = e; ed = 1'b1; er = mr[e]; end
    else       begin ech = c; ed = md[c]; er = mr[c]; end
  endtask

  task automatic check_conv(input logic [2:0] c, input int n0, input logic [15:0] res,
                            input logic [7:0] pre, input logic [15:0] edata,
                            input logic [2:0] ech, input logic ed, input logic [2:0] er);
    chk(convs == n0 + 1, "R3 conversion pulse count", convs, n0 + 1);
    chk(sel_ch == ech, (c != ech) ? "R7 pair channel" : "R2 channel field", sel_ch, ech);
    chk({sel_diff, sel_rng} == {ed, er}, "R7/R2 mode and range", {sel_diff, sel_rng}, {ed, er});
    chk(res == edata, "R4 result bits B15..B0", res, edata);
    chk(pre == 8'h00, "R4 output zero during clocks 9..16", pre, 0);
  endtask

  task automatic do_conv(input logic [2:0] c, input int nlead, input bit flip);
    logic [15:0] res, edata;
    logic [7:0]  pre;
    logic [2:0]  ech, er;
    logic        ed;
    int          n0;
    resolve(c, ech, ed, er);
    n0 = convs;
    cs_fall();
    send({c, 4'b0000}, nlead);
    edata = pat(seed, ech);
    grab(res, pre, flip);
    chk(oe == 1'b1, "R5 output enabled while selected", oe, 1);
    cs_rise();
    if (flip) chk(res == edata, "R11 sample captured at clock 16", res, edata);
    else      check_conv(c, n0, res, pre, edata, ech, ed, er);
    seed = {seed[14:0], seed[15] ^ seed[13]} + 16'h0107;
  endtask

  task automatic model_apply(input logic [6:0] pay);
    if (pay[3:0] != 4'h0) begin
      md[pay[6:4]] = pay[3];
      mr[pay[6:4]] = pay[2:0];
    end
  endtask

  task automatic do_cmd(input logic [6:0] pay, input int nlead);
    int n0;
    if (pay[3:0] == 4'h0) begin
      do_conv(pay[6:4], nlead, 1'b0);
    end else begin
      n0 = convs;
      cs_fall();
      send(pay, nlead);
      cs_rise();
      model_apply(pay);
      chk(convs == n0, "R3 configuration raises no conversion", convs, n0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic s;
    logic [15:0] res, edata;
    logic [7:0]  pre;
    logic [2:0]  ech, er;
    logic        ed;
    int          n0;
    for (int i = 0; i < 8; i++) begin md[i] = 1'b0; mr[i] = 3'b111; end
    tick(4);
    rst = 1'b0;
    tick(4);
    // R9: reset state at the ports
    chk(oe == 1'b0, "R9 output disabled after reset", oe, 0);
    chk(dout == 1'b0, "R9 output low after reset", dout, 0);
    chk({sel_ch, sel_diff, sel_rng} == 7'h0, "R9 selection outputs zero", {sel_ch, sel_diff, sel_rng}, 0);
    chk(sstrb == 1'b0, "R6 strobe low", sstrb, 0);
    // R9: default entries read back through conversions
    for (int c = 0; c < 8; c++) do_conv(3'(c), c % 3, 1'b0);

    // R1/R2/R3: every payload code, varying leading zeros
    for (int p = 0; p < 128; p++) do_cmd(7'(p), p % 4);

    // R7: mixed pair settings, then convert every channel
    for (int c = 0; c < 8; c++)
      do_cmd({3'(c), (c % 3 == 0) ? 1'b1 : 1'b0, 3'((c * 3 + 1) % 8) | 3'b001}, 1);
    for (int c = 0; c < 8; c++) do_conv(3'(c), 0, 1'b0);
    do_cmd({3'd4, 1'b0, 3'd2}, 0);
    do_cmd({3'd5, 1'b1, 3'd6}, 0);
    do_conv(3'd5, 2, 1'b0);

    // R1: long run of leading zeros
    do_conv(3'd3, 20, 1'b0);

    // R5: traffic while deselected is ignored
    n0 = convs;
    send({3'd1, 1'b1, 3'd3}, 0);
    send({3'd1, 4'b0000}, 0);
    chk(oe == 1'b0, "R5 output disabled while deselected", oe, 0);
    chk(convs == n0, "R5 no decode while deselected", convs, n0);
    chk(sstrb == 1'b0, "R6 strobe low while deselected", sstrb, 0);
    do_conv(3'd1, 0, 1'b0);

    // R8: abort in the middle of a configuration command
    cs_fall();
    clk_bit(1'b1, s);
    clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    clk_bit(1'b1, s); clk_bit(1'b1, s);
    cs_rise();
    do_conv(3'd6, 0, 1'b0);
    chk({sel_diff, sel_rng} == {md[6], mr[6]}, "R8 aborted write left entry", {sel_diff, sel_rng}, {md[6], mr[6]});

    // R8: abort in the data phase, then a clean frame
    cs_fall();
    send({3'd2, 4'b0000}, 0);
    for (int k = 0; k < 10; k++) clk_bit(1'b0, s);
    cs_rise();
    do_conv(3'd7, 1, 1'b0);

    // R10: configuration and conversion under one chip select
    resolve(3'd3, ech, ed, er);
    md[3] = 1'b1; mr[3] = 3'd5;
    if (!md[2]) begin ech = 3'd3; ed = 1'b1; er = 3'd5; end
    n0 = convs;
    cs_fall();
    send({3'd3, 1'b1, 3'd5}, 1);
    send({3'd3, 4'b0000}, 2);
    edata = pat(seed, ech);
    grab(res, pre, 1'b0);
    chk(res == edata, "R10 conversion after configuration in one frame", res, edata);
    chk({sel_diff, sel_rng} == {ed, er}, "R10 new setting applied", {sel_diff, sel_rng}, {ed, er});
    // R10: second conversion right after clock 32
    resolve(3'd0, ech, ed, er);
    seed = seed ^ 16'h5A5A;
    send({3'd0, 4'b0000}, 0);
    edata = pat(seed, ech);
    grab(res, pre, 1'b0);
    cs_rise();
    chk(res == edata, "R10 back-to-back conversion", res, edata);
    chk(convs == n0 + 2, "R10 two conversions counted", convs, n0 + 2);

    // R11: sample changes after capture do not reach the output
    do_conv(3'd4, 0, 1'b1);
    chk(sstrb == 1'b0, "R6 strobe low at end", sstrb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule